// File: doc/BRIEF.md
# Dual-Bus READY Synchroniser

This block merges ready requests from several system buses into the single ready line that a processor samples. Each bus supplies a ready line and an active-low enable qualifier. A ready line only counts while its qualifier is low, so tying a qualifier low makes that bus ready permanently valid. Any valid bus request raises the combined request.

The combined request reaches the processor through a synchroniser clocked on both edges of the processor clock. The paths for rising and falling requests differ. In two-stage mode (mode input low), a rising request is caught on a rising clock edge and confirmed on the following falling edge, and only then does the output go high. A falling request is taken directly by the falling-edge stage. In one-stage mode (mode input high), the rising-edge stage is bypassed and only the falling-edge stage samples the request. Devices that meet setup timing use one-stage mode. Asynchronous devices use two-stage mode. The mode may change from one bus cycle to the next.

Top module: `dual_ready_sync`

## Requirements
- R1: A bus request is valid when its ready line is 1 and its enable line is 0 (enable encoding: 0 = bus enabled, 1 = bus masked).
- R2: A ready line whose enable line is 1 has no effect: with every valid request absent, `ready_o` stays 0.
- R3: The combined request is the OR of all valid bus requests, so one valid bus is enough to raise `ready_o`.
- R4: While `rst_ni` is 0, `ready_o` is 0 immediately, without waiting for a clock edge, and both stages are cleared.
- R5: With `sync_mode_i` = 0, `ready_o` rises at a falling clock edge only if the combined request was 1 at the preceding rising edge and is still 1 at that falling edge.
- R6: With `sync_mode_i` = 0, a request that rises after a rising edge does not reach `ready_o` at the next falling edge. It appears one full clock period later.
- R7: With `sync_mode_i` = 1, `ready_o` takes the value of the combined request sampled at each falling edge, regardless of the rising-edge stage.
- R8: In either mode, `ready_o` drops at the first falling edge at which the combined request is 0.
- R9: The mode is read at every falling edge, so a change of `sync_mode_i` between bus cycles takes effect at the next falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Processor clock; both edges used |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_rdy_i | input | NUM_BUSES | Ready line from each bus |
| bus_en_ni | input | NUM_BUSES | Active-low qualifier for each ready line |
| sync_mode_i | input | 1 | 0 = two-stage synchronisation, 1 = rising-edge stage bypassed |
| ready_o | output | 1 | Synchronised ready to the processor |

## Verification
Several rules are checked on every clock edge. The rising-edge stage must follow the combined request. A low request at a falling edge must always clear the output (R8). A high request at a falling edge in one-stage mode must set the output (R7). In two-stage mode the output must stay low when the first stage was low at the preceding rising edge (R5, R6). Only the bench scenarios can show the rest: the qualifier masking and the OR across buses, measured at the output; the exact cycle of delay added when a request rises between edges; the asynchronous clear during reset; and mode switches from one cycle to the next.

// File: rtl/rdy_sync_pkg.sv
package rdy_sync_pkg;
   typedef enum logic {
      SYNC_TWO_STAGE = 1'b0,
      SYNC_ONE_STAGE = 1'b1
   } sync_mode_e;
endpackage

// File: rtl/rdy_qualify.sv
module rdy_qualify #(
   parameter int NUM_BUSES = 2
) (
   input  logic [NUM_BUSES-1:0] bus_rdy_i,
   input  logic [NUM_BUSES-1:0] bus_en_ni,
   output logic                 req_o
);
   logic [NUM_BUSES-1:0] valid;

   // one qualifying gate per bus
   for (genvar b = 0; b < NUM_BUSES; b++) begin : g_bus
      assign valid[b] = bus_rdy_i[b] & ~bus_en_ni[b];
   end

   assign req_o = |valid;
endmodule

// File: rtl/rdy_stage_rise.sv
module rdy_stage_rise (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_i,
   output logic q_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= 1'b0;
      else         q_o <= req_i;
   end

   // first stage captures the combined request at each rising edge
   assert_rise_capture_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i |=> q_o);
endmodule

// File: rtl/rdy_stage_fall.sv
module rdy_stage_fall
   import rdy_sync_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_i,
   input  logic stage1_i,
   input  logic mode_i,
   output logic q_o
);
   sync_mode_e mode;
   logic       d;

   assign mode = sync_mode_e'(mode_i);

   always_comb begin
      if (mode == SYNC_ONE_STAGE) d = req_i;
      else                        d = stage1_i & req_i;
   end

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= 1'b0;
      else         q_o <= d;
   end

   assert_drop_on_low_R8 : assert property (@(negedge clk_i) disable iff (!rst_ni)
      !req_i |=> !q_o);

   assert_bypass_follows_R7 : assert property (@(negedge clk_i) disable iff (!rst_ni)
      (mode_i && req_i) |=> q_o);

   assert_two_stage_gate_R6 : assert property (@(negedge clk_i) disable iff (!rst_ni)
      (!mode_i && !stage1_i) |=> !q_o);
endmodule

// File: rtl/dual_ready_sync.sv
module dual_ready_sync #(
   parameter int NUM_BUSES = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [NUM_BUSES-1:0] bus_rdy_i,
   input  logic [NUM_BUSES-1:0] bus_en_ni,
   input  logic                 sync_mode_i,
   output logic                 ready_o
);
   if (NUM_BUSES < 1) begin : g_bad_param
      $error("dual_ready_sync: NUM_BUSES must be at least 1");
   end

   logic req;
   logic stage1;

   rdy_qualify #(.NUM_BUSES(NUM_BUSES)) qual_i (
      .bus_rdy_i (bus_rdy_i),
      .bus_en_ni (bus_en_ni),
      .req_o     (req)
   );

   rdy_stage_rise rise_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req),
      .q_o    (stage1)
   );

   rdy_stage_fall fall_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (req),
      .stage1_i (stage1),
      .mode_i   (sync_mode_i),
      .q_o      (ready_o)
   );
endmodule

// File: tb/dual_ready_sync_tb_top.sv
module dual_ready_sync_tb_top;
   localparam int NB = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NB-1:0] rdy = '0;
   logic [NB-1:0] en_n = '1;
   logic          mode = 1'b0;
   logic          ready;

   int  total = 0;
   int  bad = 0;
   bit  done = 1'b0;
   bit  s1_model = 1'b0;

   bit    exp_q[$];
   string tag_q[$];

   always #10 clk = ~clk;

   dual_ready_sync #(.NUM_BUSES(NB)) dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .bus_rdy_i   (rdy),
      .bus_en_ni   (en_n),
      .sync_mode_i (mode),
      .ready_o     (ready)
   );

   task automatic check(input bit act, input bit exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: ready_o=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit comb_req(input logic [NB-1:0] r, input logic [NB-1:0] e);
      return |(r & ~e);
   endfunction

   // one clock period: inputs A before the rising edge, inputs B between rising and falling edge
   task automatic cyc(input logic [NB-1:0] ra, input logic [NB-1:0] ea,
                      input logic [NB-1:0] rb, input logic [NB-1:0] eb,
                      input bit m, input string tag);
      bit reqb;
      @(negedge clk); #3;
      rdy = ra; en_n = ea; mode = m;
      @(posedge clk);
      s1_model = comb_req(ra, ea);
      #3;
      rdy = rb; en_n = eb;
      reqb = comb_req(rb, eb);
      exp_q.push_back(m ? reqb : (s1_model & reqb));
      tag_q.push_back(tag);
   endtask

   // monitor: compares after each falling edge
   initial begin
      forever begin
         @(negedge clk); #2;
         if (exp_q.size() > 0) check(ready, exp_q.pop_front(), tag_q.pop_front());
      end
   end

   initial begin
      #5;
      check(ready, 1'b0, "R4 reset value");
      repeat (2) @(negedge clk);
      #5 rst_n = 1'b1;
      // R1 bus 0 valid, two-stage, request held all cycle
      cyc(2'b01, 2'b00, 2'b01, 2'b00, 1'b0, "R1 bus0 valid");
      cyc(2'b00, 2'b00, 2'b00, 2'b00, 1'b0, "R8 drop two-stage");
      // R2 masked requests ignored
      cyc(2'b11, 2'b11, 2'b11, 2'b11, 1'b0, "R2 both masked");
      cyc(2'b11, 2'b11, 2'b11, 2'b11, 1'b1, "R2 masked one-stage");
      // R3 only bus 1 valid
      cyc(2'b11, 2'b01, 2'b11, 2'b01, 1'b0, "R3 bus1 alone");
      cyc(2'b00, 2'b00, 2'b00, 2'b00, 1'b0, "R8 drop");
      // R6 late rise in two-stage mode
      cyc(2'b00, 2'b00, 2'b01, 2'b00, 1'b0, "R6 late rise blocked");
      cyc(2'b01, 2'b00, 2'b01, 2'b00, 1'b0, "R6 appears next cycle");
      // R8 falls between edges while high
      cyc(2'b01, 2'b00, 2'b00, 2'b00, 1'b0, "R8 mid-cycle fall");
      // R7 late rise in one-stage mode passes at once
      cyc(2'b00, 2'b00, 2'b10, 2'b00, 1'b1, "R7 one-stage late rise");
      cyc(2'b10, 2'b00, 2'b00, 2'b00, 1'b1, "R8 one-stage drop");
      // R5 rising edge saw request but it vanished before falling edge
      cyc(2'b01, 2'b00, 2'b00, 2'b00, 1'b0, "R5 needs both edges");
      // R9 mode switches each cycle
      cyc(2'b00, 2'b00, 2'b01, 2'b00, 1'b1, "R9 mode one");
      cyc(2'b00, 2'b00, 2'b01, 2'b00, 1'b0, "R9 mode two");
      cyc(2'b01, 2'b00, 2'b01, 2'b00, 1'b0, "R9 two-stage held");
      cyc(2'b01, 2'b10, 2'b01, 2'b10, 1'b1, "R9 one-stage held");
      // R4 asynchronous reset while ready high
      @(negedge clk); #5;
      check(ready, 1'b1, "R4 high before reset");
      rst_n = 1'b0; #1;
      check(ready, 1'b0, "R4 async clear");
      @(negedge clk); #5;
      check(ready, 1'b0, "R4 held in reset");
      rst_n = 1'b1; s1_model = 1'b0;
      cyc(2'b00, 2'b00, 2'b01, 2'b00, 1'b0, "R4 stage1 cleared");
      cyc(2'b01, 2'b00, 2'b01, 2'b00, 1'b0, "R5 after reset");
      @(negedge clk); #4;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: ready_o=%0b expected=finish", ready);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule